// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sits next to a small 8-bit processor core and decides which clocks may run. The core writes one 8-bit power control register through a plain register bus. From that register the block produces three enables: one for the CPU clock, one for the peripheral clock and one for the oscillator. The enables feed the clock buffering, which lies outside the block.

Two low-power modes exist. In idle, only the CPU clock is held, so timers and serial units keep working. An enabled interrupt ends idle, and so does reset. In power-down, the oscillator and every clock stop. Only reset or an enabled external interrupt ends power-down. On that wake the oscillator enable comes back first. The clock enables return only after a settling count.

The block never resets processor state when it enters a mode. It only withholds clock enables. A clock-halving select makes both clock enables pulse on every other cycle.

Top module: `pmc_top`

## Requirements
- R1: With the idle bit set and the power-down bit clear, `cpu_clk_en_o` is low while `per_clk_en_o` and `osc_en_o` stay high (halving off).
- R2: A bus write that sets the idle bit is stored at the clock edge that samples it. `cpu_clk_en_o` is high in the cycle of that write and low from the next cycle on.
- R3: Bus writes are ignored unless the block is in run mode, meaning no mode bit is set and no settling is in progress. The register read-back stays unchanged after such a write.
- R4: In idle, a high `irq_any_i` clears the idle bit at the next clock edge, and `cpu_clk_en_o` returns in the cycle after that edge.
- R5: A high `rst_i` clears every register bit at once, without waiting for a clock edge. All three enables then read high.
- R6: While the power-down bit (bit 1) is set, all three enables are low. A write with both bit 0 and bit 1 set enters power-down. Leaving power-down clears both bits, so the block returns to run mode and not to idle.
- R7: In power-down, `irq_any_i` has no effect. Only `ext_irq_i` or reset ends the mode.
- R8: `ext_irq_i` sampled in power-down raises `osc_en_o` at the next edge. Both clock enables then stay low for exactly `STAB_CYCLES` (default 16) cycles before they rise.
- R9: The general flags at bit 2 and bit 3 can be written and read back, and they change no enable.
- R10: With the halving bit (bit 7) set, each clock enable is high on alternate cycles, so it is high on half of any even-length window.
- R11: The register reads back as {halving, 0, 0, 0, flag1, flag0, power-down, idle}, from bit 7 down to bit 0. Bits 4 to 6 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock for the controller |
| rst_i | input | 1 | Active-high asynchronous reset pin |
| bus_we_i | input | 1 | Register write strobe from the core |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read-back value |
| irq_any_i | input | 1 | Any enabled interrupt is pending |
| ext_irq_i | input | 1 | An enabled external interrupt is pending |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator run enable |

## Verification
The bound checker watches several rules on every clock edge:
- the output pattern in idle;
- clock gating in the cycle after an idle-setting write;
- interrupt exit from idle;
- power-down holding against anything but an external interrupt;
- the oscillator enable rising ahead of the clock enables;
- the ban on a return to idle after power-down;
- flag stability without a write;
- the alternation under halving.

Other behaviour can only be shown by the directed scenarios:
- the asynchronous clear from the reset pin between clock edges;
- the exact length of the settling window;
- writes ignored while in idle;
- the read-back layout with the unused bits written high.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   localparam int unsigned IDL_B  = 0;
   localparam int unsigned PD_B   = 1;
   localparam int unsigned GF0_B  = 2;
   localparam int unsigned GF1_B  = 3;
   localparam int unsigned HALF_B = 7;
   localparam int unsigned MIN_REG_W = 8;

   typedef struct packed {
      logic half;
      logic gf1;
      logic gf0;
      logic pd;
      logic idl;
   } pmc_reg_t;

   typedef enum logic [1:0] {
      MODE_RUN    = 2'd0,
      MODE_IDLE   = 2'd1,
      MODE_PDOWN  = 2'd2,
      MODE_SETTLE = 2'd3
   } pmc_mode_e;

   function automatic logic [MIN_REG_W-1:0] pmc_pack(input pmc_reg_t r);
      logic [MIN_REG_W-1:0] v;
      v         = '0;
      v[IDL_B]  = r.idl;
      v[PD_B]   = r.pd;
      v[GF0_B]  = r.gf0;
      v[GF1_B]  = r.gf1;
      v[HALF_B] = r.half;
      return v;
   endfunction

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
   import pmc_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             wr_ok_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             idle_exit_i,
   input  logic             pd_exit_i,
   output pmc_reg_t         reg_o
);

   pmc_reg_t r_q;
   logic     unused_bits;

   assign unused_bits = ^wdata_i;

   // Asynchronous clear from the reset pin; hardware exits take priority over writes.
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         r_q <= '0;
      end else if (pd_exit_i) begin
         r_q.pd  <= 1'b0;
         r_q.idl <= 1'b0;
      end else if (idle_exit_i) begin
         r_q.idl <= 1'b0;
      end else if (wr_ok_i) begin
         r_q.idl  <= wdata_i[IDL_B];
         r_q.pd   <= wdata_i[PD_B];
         r_q.gf0  <= wdata_i[GF0_B];
         r_q.gf1  <= wdata_i[GF1_B];
         r_q.half <= wdata_i[HALF_B];
      end
   end

   assign reg_o = r_q;

endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
   parameter int unsigned STAB_CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic start_i,
   output logic busy_o
);

   generate
      if (STAB_CYCLES == 0) begin : g_none
         logic unused_start;
         assign unused_start = start_i ^ clk_i ^ rst_i;
         assign busy_o = 1'b0;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(STAB_CYCLES + 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) begin
               cnt_q <= '0;
            end else if (start_i) begin
               cnt_q <= CNT_W'(STAB_CYCLES);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign busy_o = (cnt_q != '0);
      end
   endgenerate

endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div #(
   parameter bit HALF_SUPPORT = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic half_i,
   output logic phase_en_o
);

   generate
      if (HALF_SUPPORT) begin : g_div
         logic tog_q;
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) begin
               tog_q <= 1'b0;
            end else if (half_i) begin
               tog_q <= ~tog_q;
            end else begin
               tog_q <= 1'b0;
            end
         end
         assign phase_en_o = ~half_i | tog_q;
      end else begin : g_flat
         logic unused_in;
         assign unused_in = half_i ^ clk_i ^ rst_i;
         assign phase_en_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pmc_top.sv
module pmc_top
   import pmc_pkg::*;
#(
   parameter int unsigned REG_W        = 8,
   parameter int unsigned STAB_CYCLES  = 16,
   parameter bit          HALF_SUPPORT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             bus_we_i,
   input  logic [REG_W-1:0] bus_wdata_i,
   output logic [REG_W-1:0] bus_rdata_o,
   input  logic             irq_any_i,
   input  logic             ext_irq_i,
   output logic             cpu_clk_en_o,
   output logic             per_clk_en_o,
   output logic             osc_en_o
);

   localparam int unsigned MAX_STAB = 65535;

   generate
      if (REG_W < MIN_REG_W) begin : g_bad_width
         $error("pmc_top: REG_W must be at least 8");
      end
      if (STAB_CYCLES > MAX_STAB) begin : g_bad_stab
         $error("pmc_top: STAB_CYCLES too large");
      end
   endgenerate

   pmc_reg_t  reg_q;
   pmc_mode_e mode;
   logic      settle_busy;
   logic      phase_en;
   logic      wr_ok;
   logic      idle_exit;
   logic      pd_exit;

   // The mode is decoded from state held by the register and the timer.
   always_comb begin
      if (reg_q.pd)         mode = MODE_PDOWN;
      else if (settle_busy) mode = MODE_SETTLE;
      else if (reg_q.idl)   mode = MODE_IDLE;
      else                  mode = MODE_RUN;
   end

   assign wr_ok     = bus_we_i  && (mode == MODE_RUN);
   assign idle_exit = irq_any_i && (mode == MODE_IDLE);
   assign pd_exit   = ext_irq_i && (mode == MODE_PDOWN);

   pmc_ctrl_reg #(.REG_W(REG_W)) u_reg (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .wr_ok_i     (wr_ok),
      .wdata_i     (bus_wdata_i),
      .idle_exit_i (idle_exit),
      .pd_exit_i   (pd_exit),
      .reg_o       (reg_q)
   );

   pmc_wake_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .start_i (pd_exit),
      .busy_o  (settle_busy)
   );

   pmc_clk_div #(.HALF_SUPPORT(HALF_SUPPORT)) u_div (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .half_i     (reg_q.half),
      .phase_en_o (phase_en)
   );

   assign osc_en_o     = (mode != MODE_PDOWN);
   assign per_clk_en_o = ((mode == MODE_RUN) || (mode == MODE_IDLE)) && phase_en;
   assign cpu_clk_en_o = (mode == MODE_RUN) && phase_en;

   generate
      if (REG_W > MIN_REG_W) begin : g_wide
         assign bus_rdata_o = {{(REG_W-MIN_REG_W){1'b0}}, pmc_pack(reg_q)};
      end else begin : g_exact
         assign bus_rdata_o = pmc_pack(reg_q);
      end
   endgenerate

endmodule

// File: rtl/pmc_sva.sv
module pmc_sva #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             bus_we_i,
   input logic [REG_W-1:0] bus_wdata_i,
   input logic [REG_W-1:0] bus_rdata_o,
   input logic             irq_any_i,
   input logic             ext_irq_i,
   input logic             cpu_clk_en_o,
   input logic             per_clk_en_o,
   input logic             osc_en_o
);

   logic unused_sva;
   assign unused_sva = ^{bus_wdata_i, bus_rdata_o};

   AST_IDLE_OUTPUTS: assert property (@(posedge clk_i) disable iff (rst_i)
      (bus_rdata_o[0] && !bus_rdata_o[1] && !bus_rdata_o[7])
      |-> (per_clk_en_o && !cpu_clk_en_o && osc_en_o)); // R1

   AST_GATE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
      (cpu_clk_en_o && bus_we_i && bus_wdata_i[0] && !bus_wdata_i[1])
      |=> (!cpu_clk_en_o && bus_rdata_o[0])); // R2

   AST_IRQ_ENDS_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (bus_rdata_o[0] && !bus_rdata_o[1] && irq_any_i)
      |=> !bus_rdata_o[0]); // R4

   AST_NO_IDLE_AFTER_PD: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(bus_rdata_o[1]) |-> !bus_rdata_o[0]); // R6

   AST_PD_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (bus_rdata_o[1] && !ext_irq_i) |=> bus_rdata_o[1]); // R7

   AST_OSC_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(osc_en_o) |-> (!cpu_clk_en_o && !per_clk_en_o)); // R8

   AST_FLAGS_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !bus_we_i |=> $stable(bus_rdata_o[3:2])); // R9

   AST_HALF_ALTERNATE: assert property (@(posedge clk_i) disable iff (rst_i)
      (bus_rdata_o[7] && per_clk_en_o && !bus_we_i) |=> !per_clk_en_o); // R10

endmodule

bind pmc_top pmc_sva #(.REG_W(REG_W)) u_sva (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .bus_we_i     (bus_we_i),
   .bus_wdata_i  (bus_wdata_i),
   .bus_rdata_o  (bus_rdata_o),
   .irq_any_i    (irq_any_i),
   .ext_irq_i    (ext_irq_i),
   .cpu_clk_en_o (cpu_clk_en_o),
   .per_clk_en_o (per_clk_en_o),
   .osc_en_o     (osc_en_o)
);

// File: tb/sim_pmc_top.sv
`timescale 1ns/1ps
module sim_pmc_top;

   localparam int STAB = 16;

   logic       clk = 1'b0;
   logic       rst;
   logic       we;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic       irq_any;
   logic       ext_irq;
   logic       cpu_en;
   logic       per_en;
   logic       osc_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   pmc_top #(.REG_W(8), .STAB_CYCLES(STAB), .HALF_SUPPORT(1'b1)) u0 (
      .clk_i        (clk),
      .rst_i        (rst),
      .bus_we_i     (we),
      .bus_wdata_i  (wdata),
      .bus_rdata_o  (rdata),
      .irq_any_i    (irq_any),
      .ext_irq_i    (ext_irq),
      .cpu_clk_en_o (cpu_en),
      .per_clk_en_o (per_en),
      .osc_en_o     (osc_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk);
      we    = 1'b1;
      wdata = v;
      @(negedge clk);
      we    = 1'b0;
      wdata = 8'h00;
   endtask

   task automatic t_reset;
      chk(rdata == 8'h00, "R5 reset value", rdata, 8'h00);
      chk({cpu_en, per_en, osc_en} == 3'b111, "R5 reset enables", {cpu_en, per_en, osc_en}, 3'b111);
   endtask

   task automatic t_layout;
      wr(8'hFC);
      chk(rdata == 8'h8C, "R11 layout, bits 4-6 read zero", rdata, 8'h8C);
      wr(8'h0C);
      chk(rdata == 8'h0C, "R9 flags read back", rdata, 8'h0C);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk({cpu_en, per_en, osc_en} == 3'b111, "R9 flags do not gate", {cpu_en, per_en, osc_en}, 3'b111);
      end
      wr(8'h00);
   endtask

   task automatic t_half;
      int hc;
      int hp;
      hc = 0;
      hp = 0;
      wr(8'h80);
      for (int i = 0; i < 8; i++) begin
         if (cpu_en) hc++;
         if (per_en) hp++;
         @(negedge clk);
      end
      chk(hc == 4, "R10 cpu enable halved", hc, 4);
      chk(hp == 4, "R10 per enable halved", hp, 4);
      wr(8'h00);
      @(negedge clk);
      chk(cpu_en == 1'b1, "R10 halving off", cpu_en, 1);
   endtask

   task automatic t_idle;
      @(negedge clk);
      we    = 1'b1;
      wdata = 8'h01;
      chk(cpu_en == 1'b1, "R2 cpu runs during write cycle", cpu_en, 1);
      @(negedge clk);
      we    = 1'b0;
      wdata = 8'h00;
      chk(rdata == 8'h01, "R2 idle bit stored", rdata, 8'h01);
      chk({cpu_en, per_en, osc_en} == 3'b011, "R1 idle enables", {cpu_en, per_en, osc_en}, 3'b011);
      wr(8'h0C);
      chk(rdata == 8'h01, "R3 write ignored in idle", rdata, 8'h01);
      @(negedge clk);
      irq_any = 1'b1;
      @(negedge clk);
      irq_any = 1'b0;
      chk(rdata == 8'h00, "R4 idle bit cleared by interrupt", rdata, 8'h00);
      chk(cpu_en == 1'b1, "R4 cpu clock restored", cpu_en, 1);
   endtask

   task automatic t_pdown;
      int lows;
      wr(8'h03);
      chk(rdata[1] == 1'b1, "R6 both bits enter power-down", rdata, 8'h03);
      chk({cpu_en, per_en, osc_en} == 3'b000, "R6 all enables low", {cpu_en, per_en, osc_en}, 3'b000);
      irq_any = 1'b1;
      repeat (3) @(negedge clk);
      irq_any = 1'b0;
      chk(rdata == 8'h03, "R7 irq_any ignored in power-down", rdata, 8'h03);
      chk(osc_en == 1'b0, "R7 oscillator still off", osc_en, 0);
      ext_irq = 1'b1;
      @(negedge clk);
      ext_irq = 1'b0;
      chk(osc_en == 1'b1, "R8 oscillator first", osc_en, 1);
      chk(rdata == 8'h00, "R6 no idle after power-down", rdata, 8'h00);
      lows = 0;
      while (!per_en && lows < 100) begin
         lows++;
         @(negedge clk);
      end
      chk(lows == STAB, "R8 settling length", lows, STAB);
      chk(cpu_en == 1'b1, "R8 cpu enable back after settling", cpu_en, 1);
   endtask

   task automatic t_async_rst;
      wr(8'h0D);
      chk(cpu_en == 1'b0, "R5 idle before reset", cpu_en, 0);
      @(negedge clk);
      #2 rst = 1'b1;
      #1;
      chk(rdata == 8'h00, "R5 asynchronous clear", rdata, 8'h00);
      chk(cpu_en == 1'b1, "R5 cpu clock restored by reset", cpu_en, 1);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(rdata == 8'h00, "R5 after release", rdata, 8'h00);
   endtask

   initial begin
      rst     = 1'b1;
      we      = 1'b0;
      wdata   = 8'h00;
      irq_any = 1'b0;
      ext_irq = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_layout();
      t_half();
      t_idle();
      t_pdown();
      t_async_rst();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule